// File: doc/BRIEF.md
# Multicast Hash Filter with Receive Event Builder

This block decides whether the destination address of an incoming frame hits a 64-bin multicast hash filter. It then builds the 16-bit receive event word for that frame. The six destination-address bytes arrive one per cycle on a byte stream. The first byte is marked by a start flag. While the bytes arrive, the block folds them into an Ethernet CRC-32. The top six bits of the resulting register form a hash index. That index is decoded onto 64 lines, each line is gated by the matching bit of a 64-bit filter register that software loads, and the 64 results are ORed into a single hit flag. A separate frame-status input supplies the frame-good indication, the error and type flags, and the individual-address match from a neighbouring block.

The event word has two layouts. When a good frame hits the filter and is not a broadcast, the hash index replaces the error and type flags in the upper six bits. In every other case those bits hold the flags. Because a clean broadcast frame with a hit yields a word that looks like a hash word carrying index 02h, the block also drives a classification flag that tells the two layouts apart.

Control is a four-state machine. IDLE waits for a start byte. COLLECT accepts address bytes. AWAIT waits for the frame status when all six bytes have come before it. EMIT presents the result for one cycle. The transitions are:
- start (any state to COLLECT, on a byte with the start flag)
- addr_done_ready (COLLECT to EMIT, last byte with status already or simultaneously seen)
- addr_done_wait (COLLECT to AWAIT, last byte without status)
- status_in (AWAIT to EMIT)
- retire (EMIT to IDLE)

Top module: `hf_mcast_filter`

## Requirements
- R1: The hash index is bits 31:26 of a 32-bit CRC register (index bit 5 = CRC bit 31). The register is preset to all ones at the first byte. It then takes the six address bytes in arrival order, each byte least significant bit first, with one update per bit: feedback = crc[31] xor data bit; crc = (crc << 1) xor (feedback ? 32'h04C11DB7 : 0).
- R2: Status bit 9 (`hashed`, also driven on its own output) equals the filter register bit selected by the hash index.
- R3: Status bit 8 equals the frame-good input latched for that frame.
- R4: When the frame is good, hits the filter and its address is not all ones, status = {index[5:0], 1, 1, 8'h00}.
- R5: Otherwise status = {0, extra, runt, crc_err, broadcast, individual, hashed, good, 8'h00}. Broadcast is 1 exactly when all 48 address bits are ones.
- R6: `hash_event` is 0 when status bit 9 is 0, when status bit 8 is 0, or when status bits 15:10 equal 02h and the address is all ones. It is 1 otherwise.
- R7: A write to filter word address w (0..3) loads filter bits 16w+15 down to 16w from the 16-bit write data. Filter bits reset to 0.
- R8: The filter value used for a frame is the one written in cycles before the cycle of that frame's first byte. Writes in that cycle or later affect only later frames.
- R9: `st_valid` is high for exactly one cycle. That cycle follows the clock edge at which both the sixth address byte and the frame status have been taken. Status, `hashed` and `hash_event` are 0 while `st_valid` is low.
- R10: Bytes without the start flag are ignored while idle, awaiting status or emitting. So are bytes beyond the sixth, and frame status presented while idle.
- R11: A start byte in any state abandons the frame in progress, including any frame status already taken, and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Address byte present |
| da_sof | input | 1 | Byte is the first of a frame |
| da_byte | input | 8 | Address byte |
| fs_valid | input | 1 | Frame status present (one cycle) |
| fs_good | input | 1 | Frame received without fault |
| fs_extra | input | 1 | Frame longer than allowed |
| fs_runt | input | 1 | Frame shorter than allowed |
| fs_crc_err | input | 1 | Frame check sequence mismatch |
| fs_ind | input | 1 | Individual address matched elsewhere |
| laf_we | input | 1 | Filter word write strobe |
| laf_waddr | input | 2 | Filter word address |
| laf_wdata | input | 16 | Filter word data |
| st_valid | output | 1 | Result strobe |
| status | output | 16 | Receive event word |
| hashed | output | 1 | Filter hit |
| hash_event | output | 1 | 1 = hash layout, 0 = normal layout |

## Verification
The bench builds the block with its default parameters: six address bytes and a 16-bit write word, which gives four filter words and the full 64-bin filter. These defaults make every bin reachable by random addresses and all four word addresses reachable by writes. The bench searches for a non-broadcast address that hashes to bin 02h, so the two look-alike event words can be compared side by side. The frame status arrives anywhere from the first byte to several cycles after the last byte. This exercises both the COLLECT-to-EMIT and the AWAIT-to-EMIT paths.

// File: rtl/hf_pkg.sv
package hf_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          HASH_W     = 6;
    localparam int          STAT_W     = 16;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [5:0]  BCAST_CODE = 6'h02;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_AWAIT   = 2'd2,
        ST_EMIT    = 2'd3
    } hf_state_e;

    typedef struct packed {
        logic good;
        logic extra;
        logic runt;
        logic crc_err;
        logic ind;
    } hf_fstat_t;

    // One byte through the CRC, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  c_in,
        input logic [BYTE_W-1:0] b_in
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[CRC_W-1] ^ b_in[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/hf_crc_unit.sv
module hf_crc_unit
    import hf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '1;
        end else if (start) begin
            crc <= crc_step_byte('1, din);
        end else if (advance) begin
            crc <= crc_step_byte(crc, din);
        end
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !advance) |=> $stable(crc)); // R10

endmodule

// File: rtl/hf_laf_bank.sv
module hf_laf_bank #(
    parameter  int WORD_W   = 16,
    parameter  int LAF_BITS = 64,
    localparam int N_WORDS  = LAF_BITS / WORD_W,
    localparam int WA_W     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [WA_W-1:0]     waddr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                load,
    output logic [LAF_BITS-1:0] active
);

    logic [LAF_BITS-1:0] shadow;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (waddr == WA_W'(w))) begin
                word_q <= wdata;
            end
        end
        assign shadow[w*WORD_W +: WORD_W] = word_q;
    end

    // The copy used by a frame is frozen at its first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (load) begin
            active <= shadow;
        end
    end

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active)); // R8

endmodule

// File: rtl/hf_hash_match.sv
module hf_hash_match #(
    parameter  int IDX_W = 6,
    localparam int LINES = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] index,
    input  logic [LINES-1:0] laf,
    output logic             hit
);

    logic [LINES-1:0] line;
    logic [LINES-1:0] gated;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign line[l]  = (index == IDX_W'(l));
        assign gated[l] = line[l] & laf[l];
    end

    assign hit = |gated;

endmodule

// File: rtl/hf_mcast_filter.sv
module hf_mcast_filter
    import hf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    parameter  int WORD_W     = 16,
    localparam int LAF_BITS   = 1 << HASH_W,
    localparam int N_WORDS    = LAF_BITS / WORD_W,
    localparam int WA_W       = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic              da_sof,
    input  logic [BYTE_W-1:0] da_byte,
    input  logic              fs_valid,
    input  logic              fs_good,
    input  logic              fs_extra,
    input  logic              fs_runt,
    input  logic              fs_crc_err,
    input  logic              fs_ind,
    input  logic              laf_we,
    input  logic [WA_W-1:0]   laf_waddr,
    input  logic [WORD_W-1:0] laf_wdata,
    output logic              st_valid,
    output logic [STAT_W-1:0] status,
    output logic              hashed,
    output logic              hash_event
);

    hf_state_e           state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic                fs_seen_q;
    hf_fstat_t           fs_q;
    logic                bcast_q;
    logic                start, take, last_byte, fs_grab;
    logic [CRC_W-1:0]    crc;
    logic [LAF_BITS-1:0] laf_active;
    logic [HASH_W-1:0]   index;
    logic                hit;

    assign start     = da_valid && da_sof;
    assign take      = da_valid && !da_sof && (state_q == ST_COLLECT);
    assign last_byte = take && (cnt_q == CNT_W'(ADDR_BYTES - 1));
    assign fs_grab   = fs_valid && !fs_seen_q &&
                       ((state_q == ST_COLLECT) || (state_q == ST_AWAIT));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (start) begin
                    state_d = ST_COLLECT;
                end else if (last_byte) begin
                    state_d = (fs_seen_q || fs_valid) ? ST_EMIT : ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (start)         state_d = ST_COLLECT;
                else if (fs_valid) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                state_d = start ? ST_COLLECT : ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-frame bookkeeping of bytes, status and broadcast detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            fs_seen_q <= 1'b0;
            fs_q      <= '0;
            bcast_q   <= 1'b0;
        end else if (start) begin
            cnt_q     <= CNT_W'(1);
            fs_seen_q <= fs_valid;
            fs_q      <= fs_valid ? hf_fstat_t'({fs_good, fs_extra, fs_runt, fs_crc_err, fs_ind})
                                  : '0;
            bcast_q   <= (da_byte == '1);
        end else begin
            if (take) begin
                cnt_q   <= cnt_q + CNT_W'(1);
                bcast_q <= bcast_q && (da_byte == '1);
            end
            if (fs_grab) begin
                fs_seen_q <= 1'b1;
                fs_q      <= {fs_good, fs_extra, fs_runt, fs_crc_err, fs_ind};
            end
        end
    end

    hf_crc_unit u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (take),
        .din     (da_byte),
        .crc     (crc)
    );

    hf_laf_bank #(
        .WORD_W   (WORD_W),
        .LAF_BITS (LAF_BITS)
    ) u_laf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (laf_we),
        .waddr  (laf_waddr),
        .wdata  (laf_wdata),
        .load   (start),
        .active (laf_active)
    );

    assign index = crc[CRC_W-1 -: HASH_W];

    hf_hash_match #(
        .IDX_W (HASH_W)
    ) u_match (
        .index (index),
        .laf   (laf_active),
        .hit   (hit)
    );

    // Output logic
    always_comb begin
        st_valid   = 1'b0;
        status     = '0;
        hashed     = 1'b0;
        hash_event = 1'b0;
        if (state_q == ST_EMIT) begin
            st_valid = 1'b1;
            hashed   = hit;
            if (hit && fs_q.good && !bcast_q) begin
                status = {index, 1'b1, 1'b1, 8'h00};
            end else begin
                status = {1'b0, fs_q.extra, fs_q.runt, fs_q.crc_err, bcast_q,
                          fs_q.ind, hit, fs_q.good, 8'h00};
            end
            hash_event = status[9] && status[8] &&
                         !((status[15:10] == BCAST_CODE) && bcast_q);
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid); // R9

    AST_EMIT_FULL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (cnt_q == CNT_W'(ADDR_BYTES)) && fs_seen_q); // R9

    AST_HASH_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && hash_event) |-> (status[9] && status[8])); // R6

    AST_NORMAL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !status[9]) |-> !status[15]); // R5

endmodule

// File: tb/tb_hf_mcast_filter.sv
module tb_hf_mcast_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        da_valid, da_sof;
    logic [7:0]  da_byte;
    logic        fs_valid, fs_good, fs_extra, fs_runt, fs_crc_err, fs_ind;
    logic        laf_we;
    logic [1:0]  laf_waddr;
    logic [15:0] laf_wdata;
    logic        st_valid;
    logic [15:0] status;
    logic        hashed, hash_event;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] laf_m;

    always #10 clk = ~clk;

    hf_mcast_filter dut (
        .clk(clk), .rst_n(rst_n),
        .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
        .fs_valid(fs_valid), .fs_good(fs_good), .fs_extra(fs_extra),
        .fs_runt(fs_runt), .fs_crc_err(fs_crc_err), .fs_ind(fs_ind),
        .laf_we(laf_we), .laf_waddr(laf_waddr), .laf_wdata(laf_wdata),
        .st_valid(st_valid), .status(status), .hashed(hashed),
        .hash_event(hash_event)
    );

    // R1 hash index from the requirement text
    function automatic logic [5:0] exp_index(input logic [47:0] da);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = '1;
        for (int k = 0; k < 6; k++) begin
            b = da[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ b[i];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [15:0] exp_status(input logic [47:0] da, input logic [63:0] laf,
        input logic g, input logic ex, input logic ru, input logic ce, input logic ind);
        logic [5:0] idx;
        logic       hit, bc;
        idx = exp_index(da);
        hit = laf[idx];
        bc  = (da == '1);
        if (hit && g && !bc) return {idx, 2'b11, 8'h00};
        return {1'b0, ex, ru, ce, bc, ind, hit, g, 8'h00};
    endfunction

    function automatic logic exp_class(input logic [15:0] s, input logic [47:0] da);
        return s[9] && s[8] && !((s[15:10] == 6'h02) && (da == '1));
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        da_valid = 0; da_sof = 0; da_byte = 0;
        fs_valid = 0; fs_good = 0; fs_extra = 0; fs_runt = 0; fs_crc_err = 0; fs_ind = 0;
        laf_we = 0; laf_waddr = 0; laf_wdata = 0;
    endtask

    task automatic wr_laf(input int w, input logic [15:0] d);
        step();
        laf_we = 1; laf_waddr = 2'(w); laf_wdata = d;
        laf_m[16*w +: 16] = d;
        step();
        laf_we = 0;
    endtask

    task automatic wr_laf_all(input logic [63:0] v);
        for (int w = 0; w < 4; w++) wr_laf(w, v[16*w +: 16]);
    endtask

    // One frame; t_fs = cycle of frame status (0 = with first byte);
    // wr_at >= 0 writes filter word wr_w during the frame.
    task automatic send_frame(input logic [47:0] da, input logic g, input logic ex,
        input logic ru, input logic ce, input logic ind, input int t_fs,
        input int wr_at, input int wr_w, input logic [15:0] wr_d, input logic extra_bytes);
        logic [15:0] es;
        logic        ec;
        int          last;
        es   = exp_status(da, laf_m, g, ex, ru, ce, ind);
        ec   = exp_class(es, da);
        last = (t_fs > 5) ? t_fs : 5;
        for (int n = 0; n <= last + 2; n++) begin
            step();
            if (n >= 1) begin
                check("R9 strobe timing", {15'b0, st_valid}, {15'b0, (n == last + 1)});
                if (n == last + 1) begin
                    check("R2/R3/R4/R5 status", status, es);
                    check("R2 hashed", {15'b0, hashed}, {15'b0, es[9]});
                    check("R6 hash_event", {15'b0, hash_event}, {15'b0, ec});
                end else begin
                    check("R9 quiet status", status, 16'h0);
                end
            end
            idle_inputs();
            if (n <= last + 1) begin
                da_valid = (n < 6) || extra_bytes;
                da_sof   = (n == 0);
                da_byte  = (n < 6) ? da[47-8*n -: 8] : 8'($urandom);
                if (n == t_fs) begin
                    fs_valid = 1; fs_good = g; fs_extra = ex; fs_runt = ru;
                    fs_crc_err = ce; fs_ind = ind;
                end
                if (n == wr_at) begin
                    laf_we = 1; laf_waddr = 2'(wr_w); laf_wdata = wr_d;
                    laf_m[16*wr_w +: 16] = wr_d;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] da, da2;
        logic [5:0]  idx;
        int          tries;
        void'($urandom(32'd20240611));
        laf_m = '0;
        idle_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // reset state
        check("R9 reset st_valid", {15'b0, st_valid}, 16'h0);
        check("R9 reset status", status, 16'h0);
        check("R6 reset hash_event", {15'b0, hash_event}, 16'h0);

        // R7 filter cleared by reset: no hit
        send_frame(48'h0100_5E01_0203, 1, 0, 0, 0, 0, 2, -1, 0, 0, 0);

        // R4 all bins on
        wr_laf_all('1);
        send_frame(48'h0100_5E7F_0A0B, 1, 0, 0, 0, 0, 5, -1, 0, 0, 0);

        // R6 broadcast exception: clean broadcast with hit reads 0B00, normal
        send_frame('1, 1, 0, 0, 0, 0, 3, -1, 0, 0, 1);
        // R5 broadcast, bad frame
        send_frame('1, 0, 1, 0, 1, 0, 8, -1, 0, 0, 0);

        // R6 non-broadcast address hashing to 02h
        da = '0; tries = 0;
        do begin
            da = {16'($urandom), 32'($urandom)} | 48'h0100_0000_0000;
            tries++;
        end while (exp_index(da) != 6'h02 && tries < 20000);
        check("R1 search found bin 02h", {10'b0, exp_index(da)}, 16'h0002);
        laf_m = '0; wr_laf_all(64'h4);
        send_frame(da, 1, 0, 0, 0, 0, 4, -1, 0, 0, 0);

        // R2/R7 single selected bin, then a neighbour only
        da  = 48'h3333_0000_00FB;
        idx = exp_index(da);
        laf_m = '0; wr_laf_all(64'd1 << idx);
        send_frame(da, 1, 0, 0, 0, 1, 1, -1, 0, 0, 0);
        wr_laf_all(~(64'd1 << idx));
        send_frame(da, 1, 0, 0, 0, 1, 0, -1, 0, 0, 0);

        // R8 mid-frame write does not reach the current frame
        laf_m = '0; wr_laf_all('0);
        begin
            logic [63:0] keep;
            keep = laf_m;
            da2  = 48'h0100_5E00_00FC;
            idx  = exp_index(da2);
            // expected values come from the filter captured before the frame
            send_frame(da2, 1, 0, 0, 0, 0, 6, 2, idx / 16, 16'hFFFF, 0);
            check("R8 filter model advanced", {15'b0, laf_m[idx]}, 16'h1);
            check("R8 previous filter bin clear", {15'b0, keep[idx]}, 16'h0);
        end
        send_frame(da2, 1, 0, 0, 0, 0, 6, -1, 0, 0, 0);

        // R10 idle bytes and status ignored
        step();
        da_valid = 1; da_sof = 0; da_byte = 8'hFF; fs_valid = 1; fs_good = 1;
        step();
        idle_inputs();
        for (int i = 0; i < 3; i++) begin
            step();
            check("R10 no strobe from idle input", {15'b0, st_valid}, 16'h0);
        end
        send_frame(48'h0100_5E11_2233, 1, 0, 0, 0, 0, 9, -1, 0, 0, 1);

        // R11 restart abandons a partial frame and its status
        for (int n = 0; n < 3; n++) begin
            step();
            if (n >= 1) check("R11 no strobe on partial frame", {15'b0, st_valid}, 16'h0);
            idle_inputs();
            da_valid = 1; da_sof = (n == 0); da_byte = 8'hFF;
            if (n == 1) begin fs_valid = 1; fs_good = 1; end
        end
        send_frame(48'hFFFF_FF00_0000, 1, 1, 0, 0, 0, 7, -1, 0, 0, 0);

        // random mix
        for (int f = 0; f < 300; f++) begin
            if ($urandom % 3 == 0) wr_laf($urandom % 4, 16'($urandom));
            if ($urandom % 8 == 0) da = '1;
            else da = {16'($urandom), 32'($urandom)};
            send_frame(da, ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), $urandom % 11,
                       (($urandom % 5) == 0) ? int'($urandom % 6) : -1,
                       $urandom % 4, 16'($urandom), 1'($urandom));
        end

        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule